// File: doc/BRIEF.md
# Cache-Block Operation Permission Unit

This unit sits beside a processor core's load/store path and handles the three cache-block instructions: zeroing a block, cleaning or flushing a block, and invalidating a block. For each request it gets the operation, a byte address, the current privilege mode and the virtualization flag. It also gets the enable bits held by the machine-level, hypervisor-level and supervisor-level environment-configuration registers, and the outcome of a read/write permission probe that another unit has already run on the block. The unit turns all of this into either an exception code or a permitted operation.

A permitted zero operation clears every byte of the aligned block. It uses a one-byte write port, one byte per cycle, and ignores whether the region is cacheable. Clean, flush and invalidate do no data movement, because there is no cache hierarchy to act on. Their whole effect is the permission decision.

A small state machine with three states controls the handshake. ST_IDLE accepts a request. ST_FILL issues the zero writes. ST_REPORT raises `done` for one cycle, together with the exception, if there is one. The transitions are:
- ACCEPT_FAULT: ST_IDLE to ST_REPORT.
- ACCEPT_FILL: ST_IDLE to ST_FILL.
- ACCEPT_PASS: ST_IDLE to ST_REPORT, taken by a permitted management operation.
- FILL_STEP: ST_FILL to ST_FILL.
- FILL_END: ST_FILL to ST_REPORT, taken after the last byte.
- REPORT_END: ST_REPORT to ST_IDLE.

Top module: `cbo_gate`

## Requirements
- R1: A permitted zero operation writes the byte value 0 to BLK_BYTES consecutive addresses. The first address is the request address with its low log2(BLK_BYTES) bits cleared, and each address is one higher than the last, one write per cycle.
- R2: Each operation reads one bit of each enable vector. Operation code 0 (zero) reads bit 0. Codes 1 (clean) and 2 (flush) read bit 1. Code 3 (invalidate) reads bit 2. The other bits have no effect.
- R3: Modes are encoded U=0, S=1, M=3. If the mode is below M and the machine-level enable bit is 0, the result is exception code 2 (illegal instruction). This check has the highest priority.
- R4: If check R3 passes and virtualization is on, code 22 (virtual instruction) is raised in either of two cases: the mode is S or U and the hypervisor-level bit is 0, or the mode is U and the supervisor-level bit is 0.
- R5: If checks R3 and R4 pass, the mode is U and the supervisor-level bit is 0, the result is exception code 2.
- R6: A zero operation that passes R3 to R5 but lacks write permission (`prb_wr_ok`=0) reports code 7 (store access fault) and writes nothing.
- R7: A clean, flush or invalidate that passes R3 to R5 succeeds if the block is readable. If it is not readable, it succeeds if the block is writable. If it is neither, it reports code 7.
- R8: A clean, flush or invalidate never drives a write, whether it succeeds or fails.
- R9: A request is accepted only while `busy` is 0. A request presented while busy is ignored. `done` is high for exactly one cycle per accepted request. `exc_valid` is high only together with `done`.
- R10: After reset, `busy`, `done`, `exc_valid` and `mem_we` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_op | input | 2 | 0 zero, 1 clean, 2 flush, 3 invalidate |
| req_addr | input | ADDR_W | Byte address of the request |
| req_mode | input | 2 | Privilege mode: U=0, S=1, M=3 |
| req_virt | input | 1 | Virtualization on |
| men_cfg | input | 3 | Machine-level enables {inval, clean/flush, zero} |
| hen_cfg | input | 3 | Hypervisor-level enables, same layout |
| sen_cfg | input | 3 | Supervisor-level enables, same layout |
| prb_rd_ok | input | 1 | Probe: block readable |
| prb_wr_ok | input | 1 | Probe: block writable |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion pulse |
| exc_valid | output | 1 | Completion carries an exception |
| exc_code | output | 5 | Exception code (2, 7 or 22), 0 when no exception |
| mem_we | output | 1 | Byte write strobe |
| mem_addr | output | ADDR_W | Byte write address |
| mem_wdata | output | 8 | Byte write data |

## Verification
A request is accepted at the clock edge that sees `req_valid` while the unit is idle. In the cycle after that edge, a faulting request or a permitted management operation shows `done`. A permitted zero shows `mem_we` instead, for BLK_BYTES cycles, and then shows `done` in the next cycle, BLK_BYTES+1 cycles after acceptance. The bench drives inputs on the falling edge and samples once per falling edge after acceptance. It counts those samples and compares the cycle of `done` with the expected cycle, which it computes from the operation and the model's verdict. The bench sweeps every operation, mode, virtualization setting, enable combination and probe result. In each case it holds the enable bits that the operation does not select at the opposite value. The recorded write addresses are compared one by one against the aligned base plus the write index.

// File: rtl/cbo_gate_pkg.sv
package cbo_gate_pkg;

    typedef enum logic [1:0] {
        OP_ZERO  = 2'd0,
        OP_CLEAN = 2'd1,
        OP_FLUSH = 2'd2,
        OP_INVAL = 2'd3
    } cbo_op_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FILL   = 2'd1,
        ST_REPORT = 2'd2
    } cbo_state_e;

    localparam logic [1:0] MODE_U = 2'd0;
    localparam logic [1:0] MODE_S = 2'd1;
    localparam logic [1:0] MODE_M = 2'd3;

    localparam int        CODE_W      = 5;
    localparam logic [4:0] EXC_ILLEGAL = 5'd2;
    localparam logic [4:0] EXC_STORE   = 5'd7;
    localparam logic [4:0] EXC_VIRT    = 5'd22;

    localparam int NUM_FLD   = 3;
    localparam int FLD_ZERO  = 0;
    localparam int FLD_CLFL  = 1;
    localparam int FLD_INVAL = 2;

endpackage

// File: rtl/cbo_perm.sv
module cbo_perm
    import cbo_gate_pkg::*;
(
    input  logic [1:0]         op,
    input  logic [1:0]         mode,
    input  logic               virt,
    input  logic [NUM_FLD-1:0] m_en,
    input  logic [NUM_FLD-1:0] h_en,
    input  logic [NUM_FLD-1:0] s_en,
    input  logic               rd_ok,
    input  logic               wr_ok,
    output logic               fault,
    output logic [CODE_W-1:0]  code,
    output logic               do_fill
);

    logic [1:0] fld;
    logic       m_bit, h_bit, s_bit;
    logic       below_m, s_or_lower, below_s;

    always_comb begin
        unique case (cbo_op_e'(op))
            OP_ZERO:            fld = 2'(FLD_ZERO);
            OP_CLEAN, OP_FLUSH: fld = 2'(FLD_CLFL);
            OP_INVAL:           fld = 2'(FLD_INVAL);
            default:            fld = 2'(FLD_ZERO);
        endcase
    end

    assign m_bit      = m_en[fld];
    assign h_bit      = h_en[fld];
    assign s_bit      = s_en[fld];
    assign below_m    = (mode < MODE_M);
    assign s_or_lower = (mode <= MODE_S);
    assign below_s    = (mode < MODE_S);

    always_comb begin
        fault   = 1'b0;
        code    = '0;
        do_fill = 1'b0;
        if (below_m && !m_bit) begin
            fault = 1'b1;
            code  = EXC_ILLEGAL;
        end else if (virt && ((s_or_lower && !h_bit) || (below_s && !s_bit))) begin
            fault = 1'b1;
            code  = EXC_VIRT;
        end else if (below_s && !s_bit) begin
            fault = 1'b1;
            code  = EXC_ILLEGAL;
        end else if (cbo_op_e'(op) == OP_ZERO) begin
            if (wr_ok) begin
                do_fill = 1'b1;
            end else begin
                fault = 1'b1;
                code  = EXC_STORE;
            end
        end else if (!rd_ok && !wr_ok) begin
            fault = 1'b1;
            code  = EXC_STORE;
        end
    end

endmodule

// File: rtl/cbo_fill_ctr.sv
module cbo_fill_ctr #(
    parameter int ADDR_W    = 16,
    parameter int BLK_BYTES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] wr_addr,
    output logic              last
);

    localparam int OFS_W = $clog2(BLK_BYTES);
    localparam int CNT_W = (OFS_W > 0) ? OFS_W : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BLK_BYTES - 1);

    logic [ADDR_W-1:0] aligned;
    logic [ADDR_W-1:0] base_q;
    logic [CNT_W-1:0]  cnt_q;

    generate
        if (OFS_W == 0) begin : g_no_align
            assign aligned = addr_in;
        end else begin : g_align
            assign aligned = {addr_in[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= '0;
        end else if (load) begin
            base_q <= aligned;
            cnt_q  <= '0;
        end else if (step) begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    assign wr_addr = base_q | ADDR_W'(cnt_q);
    assign last    = (cnt_q == CNT_LAST);

endmodule

// File: rtl/cbo_gate.sv
module cbo_gate
    import cbo_gate_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int BLK_BYTES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_mode,
    input  logic              req_virt,
    input  logic [2:0]        men_cfg,
    input  logic [2:0]        hen_cfg,
    input  logic [2:0]        sen_cfg,
    input  logic              prb_rd_ok,
    input  logic              prb_wr_ok,
    output logic              busy,
    output logic              done,
    output logic              exc_valid,
    output logic [4:0]        exc_code,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata
);

    cbo_state_e        state_q, state_d;
    logic              accept;
    logic              p_fault, p_fill;
    logic [CODE_W-1:0] p_code;
    logic              exc_q;
    logic [CODE_W-1:0] code_q;
    logic              fill_last;
    logic [ADDR_W-1:0] fill_addr;

    assign accept = req_valid && (state_q == ST_IDLE);

    cbo_perm u_perm (
        .op      (req_op),
        .mode    (req_mode),
        .virt    (req_virt),
        .m_en    (men_cfg),
        .h_en    (hen_cfg),
        .s_en    (sen_cfg),
        .rd_ok   (prb_rd_ok),
        .wr_ok   (prb_wr_ok),
        .fault   (p_fault),
        .code    (p_code),
        .do_fill (p_fill)
    );

    cbo_fill_ctr #(
        .ADDR_W    (ADDR_W),
        .BLK_BYTES (BLK_BYTES)
    ) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .step    (state_q == ST_FILL),
        .addr_in (req_addr),
        .wr_addr (fill_addr),
        .last    (fill_last)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (p_fault)     state_d = ST_REPORT;   // ACCEPT_FAULT
                    else if (p_fill) state_d = ST_FILL;     // ACCEPT_FILL
                    else             state_d = ST_REPORT;   // ACCEPT_PASS
                end
            end
            ST_FILL: begin
                if (fill_last) state_d = ST_REPORT;         // FILL_END
            end
            ST_REPORT: state_d = ST_IDLE;                   // REPORT_END
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register and captured verdict
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            exc_q   <= 1'b0;
            code_q  <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                exc_q  <= p_fault;
                code_q <= p_code;
            end
        end
    end

    // outputs
    always_comb begin
        busy      = 1'b0;
        done      = 1'b0;
        exc_valid = 1'b0;
        exc_code  = '0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = 8'h00;
        unique case (state_q)
            ST_IDLE: ;
            ST_FILL: begin
                busy     = 1'b1;
                mem_we   = 1'b1;
                mem_addr = fill_addr;
            end
            ST_REPORT: begin
                busy      = 1'b1;
                done      = 1'b1;
                exc_valid = exc_q;
                exc_code  = exc_q ? code_q : '0;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/cbo_gate_chk.sv
module cbo_gate_chk #(
    parameter int ADDR_W    = 16,
    parameter int BLK_BYTES = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              exc_valid,
    input logic [4:0]        exc_code,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [7:0]        mem_wdata
);

    localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'(BLK_BYTES - 1);

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    exc_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |-> done);

    // R3
    exc_code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |-> (exc_code == 5'd2 || exc_code == 5'd7 || exc_code == 5'd22));

    // R1
    wdata_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_wdata == 8'h00 && busy && !done));

    // R1
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) + 1'b1));

    // R1
    addr_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !$past(mem_we)) |-> ((mem_addr & LOW_MASK) == '0));

    // R10
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!busy && !done && !mem_we));

endmodule

bind cbo_gate cbo_gate_chk #(.ADDR_W(ADDR_W), .BLK_BYTES(BLK_BYTES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .exc_valid (exc_valid),
    .exc_code  (exc_code),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata)
);

// File: tb/test_cbo_gate.sv
`timescale 1ns/1ps
module test_cbo_gate;

    localparam int AW  = 16;
    localparam int BLK = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [1:0]    req_op = '0;
    logic [AW-1:0] req_addr = '0;
    logic [1:0]    req_mode = '0;
    logic          req_virt = 1'b0;
    logic [2:0]    men_cfg = '0, hen_cfg = '0, sen_cfg = '0;
    logic          prb_rd_ok = 1'b0, prb_wr_ok = 1'b0;
    logic          busy, done, exc_valid, mem_we;
    logic [4:0]    exc_code;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    cbo_gate #(.ADDR_W(AW), .BLK_BYTES(BLK)) i_cbo_gate (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_mode(req_mode), .req_virt(req_virt),
        .men_cfg(men_cfg), .hen_cfg(hen_cfg), .sen_cfg(sen_cfg),
        .prb_rd_ok(prb_rd_ok), .prb_wr_ok(prb_wr_ok), .busy(busy), .done(done),
        .exc_valid(exc_valid), .exc_code(exc_code), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // model verdict: code 0 means success
    function automatic int model_code(input int op, input int mode, input bit virt,
                                      input bit m, input bit h, input bit s,
                                      input bit rd, input bit wr);
        if (mode < 3 && !m) return 2;
        if (virt && ((mode <= 1 && !h) || (mode < 1 && !s))) return 22;
        if (mode < 1 && !s) return 2;
        if (op == 0) return wr ? 0 : 7;
        return (rd || wr) ? 0 : 7;
    endfunction

    function automatic string code_tag(input int op, input int mode, input bit virt,
                                       input bit m, input bit h, input bit s);
        if (mode < 3 && !m) return "R2/R3";
        if (virt && ((mode <= 1 && !h) || (mode < 1 && !s))) return "R2/R4";
        if (mode < 1 && !s) return "R2/R5";
        return (op == 0) ? "R6" : "R7";
    endfunction

    task automatic run_case(input int op, input int mode, input bit virt,
                            input bit m, input bit h, input bit s,
                            input bit rd, input bit wr, input logic [AW-1:0] addr);
        int fld, ecode, exp_cyc, exp_wr, cyc, done_cyc, got_code, nwr;
        bit got_exc;
        logic [AW-1:0] base;
        string tag;
        fld   = (op == 0) ? 0 : ((op == 3) ? 2 : 1);
        ecode = model_code(op, mode, virt, m, h, s, rd, wr);
        tag   = code_tag(op, mode, virt, m, h, s);
        exp_wr  = (op == 0 && ecode == 0) ? BLK : 0;
        exp_cyc = exp_wr + 1;
        base    = addr & ~AW'(BLK - 1);
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'(op); req_mode = 2'(mode); req_virt = virt;
        req_addr = addr; prb_rd_ok = rd; prb_wr_ok = wr;
        // selected bit takes the case value, the other bits the opposite (R2)
        men_cfg = m ? 3'b001 << fld : ~(3'b001 << fld);
        hen_cfg = h ? 3'b001 << fld : ~(3'b001 << fld);
        sen_cfg = s ? 3'b001 << fld : ~(3'b001 << fld);
        cyc = 0; done_cyc = 0; nwr = 0; got_exc = 0; got_code = 0;
        while (done_cyc == 0 && cyc < BLK + 4) begin
            @(negedge clk);
            req_valid = 1'b0;
            cyc++;
            if (mem_we) begin
                check(mem_addr == base + AW'(nwr) && mem_wdata == 8'h00,
                      (op == 0) ? "R1 write addr" : "R8 write addr",
                      int'(mem_addr), int'(base) + nwr);
                nwr++;
            end
            if (done) begin
                done_cyc = cyc; got_exc = exc_valid; got_code = int'(exc_code);
            end
        end
        check(done_cyc == exp_cyc, "R9 done cycle", done_cyc, exp_cyc);
        check(nwr == exp_wr, (op == 0) ? "R1 write count" : "R8 no writes", nwr, exp_wr);
        check(got_exc == (ecode != 0) && got_code == ecode, tag, got_code, ecode);
        @(negedge clk);
        check(!done && !busy, "R9 done single pulse", int'(done), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int idx;
        repeat (3) @(negedge clk);
        check(!busy && !done && !exc_valid && !mem_we, "R10 reset outputs",
              int'({busy, done, exc_valid, mem_we}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !mem_we, "R10 idle after reset", int'(busy), 0);

        idx = 0;
        for (int op = 0; op < 4; op++)
            for (int mi = 0; mi < 3; mi++)
                for (int v = 0; v < 2; v++)
                    for (int en = 0; en < 8; en++)
                        for (int pr = 0; pr < 4; pr++) begin
                            run_case(op, (mi == 2) ? 3 : mi, v[0], en[2], en[1], en[0],
                                     pr[1], pr[0], AW'(idx * 173 + 5));
                            idx++;
                        end

        // R9: a request presented while busy is ignored
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'd0; req_mode = 2'd3; req_virt = 1'b0;
        req_addr = 16'h1237; men_cfg = 3'b111; hen_cfg = 3'b111; sen_cfg = 3'b111;
        prb_rd_ok = 1'b1; prb_wr_ok = 1'b1;
        @(negedge clk);
        // intruding request: U mode with machine enables cleared would fault
        req_op = 2'd3; req_mode = 2'd0; men_cfg = 3'b000; req_addr = 16'h4000;
        begin
            int nw, nd, ne;
            nw = 0; nd = 0; ne = 0;
            for (int c = 0; c < BLK + 1; c++) begin
                if (c == BLK - 1) req_valid = 1'b0;
                if (mem_we) begin
                    check(mem_addr == 16'h1230 + AW'(nw), "R9 busy ignore addr",
                          int'(mem_addr), 16'h1230 + nw);
                    nw++;
                end
                if (done) nd++;
                if (exc_valid) ne++;
                @(negedge clk);
            end
            check(nw == BLK, "R9 busy ignore writes", nw, BLK);
            check(nd == 1 && ne == 0, "R9 busy ignore done", nd * 10 + ne, 10);
        end
        repeat (2) @(negedge clk);
        check(!busy && !done && !mem_we, "R9 idle after ignore", int'(busy), 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule